// File: doc/BRIEF.md
# Aligned PWM Channel with Fault Override

This block is a single pulse-width modulation channel. A free-running tap generator derives eleven power-of-two tick rates from the master clock. Two linear dividers each scale a chosen tap by a programmable integer. One of these thirteen tick sources advances the channel counter, which is compared against a period value and a duty value to produce a compare level. That level drives a complementary high-side/low-side output pair.

The waveform is either edge aligned or centre aligned. In edge-aligned mode the counter saws upward and wraps. In centre-aligned mode it ramps up to the period value and back down, so the same settings give twice the period. Period, duty and alignment are captured only when the counter returns to zero. A running cycle therefore finishes with the settings it started with.

A fault input overrides both outputs without waiting for a clock edge. It forces each output to its own programmed level. The fault is held after the input drops, until it is cleared explicitly.

Top module: `apwm_channel`

## Requirements
- R1: While reset is asserted, and until the first channel tick after reset, out_hi is 0 and out_lo is 1.
- R2: A tap_sel code n from 0 to 10 advances the counter once every 2^n master-clock cycles. An edge-aligned waveform with period value P therefore repeats every P·2^n master clocks.
- R3: tap_sel code 11 selects linear divider A and code 12 selects linear divider B. Each divider ticks once every 2^t·N master clocks, where t is its own tap code and N is its divide value. A t above 10 acts as 10, and an N of 0 acts as 1.
- R4: tap_sel codes 13 to 15 stop the counter, so both outputs hold their level.
- R5: Edge-aligned mode (center_en = 0) has a period of P ticks. For a duty value D with 0 < D < P, out_hi is 1 for P − D of those ticks.
- R6: Centre-aligned mode (center_en = 1) has a period of 2·P ticks. For 0 < D < P, out_hi is 1 for 2·(P − D) of those ticks, and the count never exceeds P.
- R7: A duty value of 0 keeps out_hi at 1. A duty value greater than or equal to P keeps out_hi at 0. Both hold in either alignment.
- R8: When no fault is active, out_lo is always the inverse of out_hi.
- R9: A new period, duty or alignment takes effect only when the counter returns to zero. A duty change made mid-cycle leaves the rest of that cycle unchanged.
- R10: While fault_in is 1, out_hi equals flt_lvl_hi and out_lo equals flt_lvl_lo, with no clock edge needed.
- R11: After fault_in returns to 0, the override stays in force until a clock edge samples fault_clr at 1 with fault_in at 0. A fault_clr pulse while fault_in is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tap_sel | input | 4 | Channel tick source: 0..10 power-of-two tap, 11 divider A, 12 divider B, 13..15 stopped |
| diva_tap | input | 4 | Tap code feeding divider A |
| diva_val | input | 8 | Divide value of divider A |
| divb_tap | input | 4 | Tap code feeding divider B |
| divb_val | input | 8 | Divide value of divider B |
| center_en | input | 1 | 1 selects centre-aligned counting |
| period_in | input | 16 | Period value P |
| duty_in | input | 16 | Duty value D |
| fault_in | input | 1 | Asynchronous fault request, active high |
| fault_clr | input | 1 | Clears a held fault once fault_in is low |
| flt_lvl_hi | input | 1 | Level forced on out_hi during a fault |
| flt_lvl_lo | input | 1 | Level forced on out_lo during a fault |
| out_hi | output | 1 | High-side output |
| out_lo | output | 1 | Low-side output |

## Verification
The bench targets the centre-aligned turnaround. A compare that treated the up ramp and the down ramp alike would be high for one tick too many or too few per cycle. It also covers the extremes of duty. There, a design without the special cases would produce a one-tick sliver at the top of a centre-aligned ramp instead of a flat level.

A duty change is made right after a rising edge. A design that loaded it at once would cut the high phase short rather than finishing the cycle.

The fault sequence covers three errors:
- a clear applied while the fault is still asserted;
- an input that drops, which a design without a latch would release at once;
- level changes during the held state, which a design that registered the override would show a cycle late.

The slowest tap and the divider clamping cases are also measured.

// File: rtl/apwm_pkg.sv
package apwm_pkg;

   typedef enum logic {
      DIR_DOWN = 1'b0,
      DIR_UP   = 1'b1
   } cnt_dir_e;

   // smallest number of bits that can index a code space of n entries
   function automatic int code_bits(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/apwm_taps.sv
// Free-running binary counter; tick n pulses once every 2**n cycles.
module apwm_taps #(
   parameter int NUM_TAPS = 11
) (
   input  logic                clk,
   input  logic                rst_n,
   output logic [NUM_TAPS-1:0] taps_o
);
   localparam int PRE_W = NUM_TAPS - 1;

   logic [PRE_W-1:0] pre_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pre_q <= '0;
      else        pre_q <= pre_q + PRE_W'(1);
   end

   assign taps_o[0] = 1'b1;

   for (genvar n = 1; n < NUM_TAPS; n++) begin : g_tap
      assign taps_o[n] = &pre_q[n-1:0];
   end

endmodule

// File: rtl/apwm_lindiv.sv
// Linear divider: counts ticks of one selected tap and passes every N-th.
module apwm_lindiv #(
   parameter int NUM_TAPS = 11,
   parameter int SEL_W    = 4,
   parameter int DIV_W    = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_TAPS-1:0] taps_i,
   input  logic [SEL_W-1:0]    tap_idx_i,
   input  logic [DIV_W-1:0]    div_i,
   output logic                tick_o
);
   localparam logic [SEL_W-1:0] LAST_TAP = SEL_W'(NUM_TAPS - 1);

   logic [SEL_W-1:0] sel;
   logic             src_tick;
   logic [DIV_W-1:0] div_eff;
   logic [DIV_W-1:0] dcnt_q;
   logic             at_end;

   assign sel      = (tap_idx_i > LAST_TAP) ? LAST_TAP : tap_idx_i;
   assign src_tick = taps_i[sel];
   assign div_eff  = (div_i == '0) ? DIV_W'(1) : div_i;
   assign at_end   = (dcnt_q >= div_eff - DIV_W'(1));
   assign tick_o   = src_tick & at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dcnt_q <= '0;
      end else if (src_tick) begin
         if (at_end) dcnt_q <= '0;
         else        dcnt_q <= dcnt_q + DIV_W'(1);
      end
   end

endmodule

// File: rtl/apwm_updown.sv
// Channel counter with shadowed period, duty and alignment, plus compare.
module apwm_updown
   import apwm_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             center_i,
   input  logic [CNT_W-1:0] period_i,
   input  logic [CNT_W-1:0] duty_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] per_o,
   output logic [CNT_W-1:0] dty_o,
   output logic             bnd_o,
   output logic             oc_o
);
   logic [CNT_W-1:0] cnt_q, per_q, dty_q;
   logic             ctr_q;
   cnt_dir_e         dir_q;

   logic [CNT_W-1:0] nxt_cnt;
   cnt_dir_e         nxt_dir;
   logic             wrap;

   // next-state of the count
   always_comb begin
      nxt_cnt = '0;
      nxt_dir = DIR_UP;
      if (per_q == '0) begin
         nxt_cnt = '0;
      end else if (!ctr_q) begin
         if (cnt_q >= per_q - CNT_W'(1)) nxt_cnt = '0;
         else                            nxt_cnt = cnt_q + CNT_W'(1);
      end else if (dir_q == DIR_UP && cnt_q < per_q) begin
         nxt_cnt = cnt_q + CNT_W'(1);
      end else begin
         nxt_cnt = cnt_q - CNT_W'(1);
         nxt_dir = (nxt_cnt == '0) ? DIR_UP : DIR_DOWN;
      end
   end

   assign wrap  = (nxt_cnt == '0);
   assign bnd_o = tick_i & wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         per_q <= '0;
         dty_q <= '1;
         ctr_q <= 1'b0;
         dir_q <= DIR_UP;
      end else if (tick_i) begin
         cnt_q <= nxt_cnt;
         dir_q <= nxt_dir;
         if (wrap) begin
            per_q <= period_i;
            dty_q <= duty_i;
            ctr_q <= center_i;
         end
      end
   end

   // compare: rising ramp switches at D, falling ramp releases after D+1
   always_comb begin
      if (dty_q == '0)          oc_o = 1'b1;
      else if (dty_q >= per_q)  oc_o = 1'b0;
      else if (dir_q == DIR_UP) oc_o = (cnt_q >= dty_q);
      else                      oc_o = (cnt_q > dty_q);
   end

   assign cnt_o = cnt_q;
   assign per_o = per_q;
   assign dty_o = dty_q;

endmodule

// File: rtl/apwm_fault.sv
// Fault latch and output override; the input path bypasses every register.
module apwm_fault (
   input  logic clk,
   input  logic rst_n,
   input  logic fault_i,
   input  logic clr_i,
   input  logic lvl_hi_i,
   input  logic lvl_lo_i,
   input  logic oc_i,
   output logic held_o,
   output logic hi_o,
   output logic lo_o
);
   logic held_q;
   logic force_en;

   always_ff @(posedge clk or posedge fault_i or negedge rst_n) begin
      if (!rst_n)       held_q <= 1'b0;
      else if (fault_i) held_q <= 1'b1;
      else if (clr_i)   held_q <= 1'b0;
   end

   assign force_en = fault_i | held_q;
   assign hi_o     = force_en ? lvl_hi_i : oc_i;
   assign lo_o     = force_en ? lvl_lo_i : ~oc_i;
   assign held_o   = held_q;

endmodule

// File: rtl/apwm_channel.sv
module apwm_channel
   import apwm_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter int DIV_W    = 8,
   parameter int NUM_TAPS = 11,
   parameter int NUM_DIV  = 2,
   localparam int SEL_W   = code_bits(NUM_TAPS + NUM_DIV)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] tap_sel,
   input  logic [SEL_W-1:0] diva_tap,
   input  logic [DIV_W-1:0] diva_val,
   input  logic [SEL_W-1:0] divb_tap,
   input  logic [DIV_W-1:0] divb_val,
   input  logic             center_en,
   input  logic [CNT_W-1:0] period_in,
   input  logic [CNT_W-1:0] duty_in,
   input  logic             fault_in,
   input  logic             fault_clr,
   input  logic             flt_lvl_hi,
   input  logic             flt_lvl_lo,
   output logic             out_hi,
   output logic             out_lo
);
   localparam logic [SEL_W-1:0] SEL_DIV0 = SEL_W'(NUM_TAPS);

   if (CNT_W < 2) begin : g_bad_cnt
      $error("apwm_channel: CNT_W must be at least 2");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("apwm_channel: DIV_W must be at least 1");
   end
   if (NUM_TAPS < 2) begin : g_bad_taps
      $error("apwm_channel: NUM_TAPS must be at least 2");
   end
   if (NUM_DIV != 2) begin : g_bad_ndiv
      $error("apwm_channel: the port list carries exactly two dividers");
   end

   logic [NUM_TAPS-1:0] taps;
   logic [NUM_DIV-1:0]  div_tick;
   logic [SEL_W-1:0]    dtap [NUM_DIV];
   logic [DIV_W-1:0]    dval [NUM_DIV];
   logic                ch_tick;

   logic [CNT_W-1:0]    cnt, per_q, dty_q;
   logic                bnd, oc, flt_q;

   assign dtap[0] = diva_tap;
   assign dval[0] = diva_val;
   assign dtap[1] = divb_tap;
   assign dval[1] = divb_val;

   apwm_taps #(.NUM_TAPS(NUM_TAPS)) u_taps (
      .clk    (clk),
      .rst_n  (rst_n),
      .taps_o (taps)
   );

   for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
      apwm_lindiv #(
         .NUM_TAPS (NUM_TAPS),
         .SEL_W    (SEL_W),
         .DIV_W    (DIV_W)
      ) u_div (
         .clk       (clk),
         .rst_n     (rst_n),
         .taps_i    (taps),
         .tap_idx_i (dtap[g]),
         .div_i     (dval[g]),
         .tick_o    (div_tick[g])
      );
   end

   // tick source: direct tap, one of the dividers, or nothing
   always_comb begin
      ch_tick = 1'b0;
      if (tap_sel < SEL_DIV0) begin
         ch_tick = taps[tap_sel];
      end else begin
         for (int k = 0; k < NUM_DIV; k++) begin
            if (tap_sel == SEL_DIV0 + SEL_W'(k)) ch_tick = div_tick[k];
         end
      end
   end

   apwm_updown #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (ch_tick),
      .center_i (center_en),
      .period_i (period_in),
      .duty_i   (duty_in),
      .cnt_o    (cnt),
      .per_o    (per_q),
      .dty_o    (dty_q),
      .bnd_o    (bnd),
      .oc_o     (oc)
   );

   apwm_fault u_flt (
      .clk      (clk),
      .rst_n    (rst_n),
      .fault_i  (fault_in),
      .clr_i    (fault_clr),
      .lvl_hi_i (flt_lvl_hi),
      .lvl_lo_i (flt_lvl_lo),
      .oc_i     (oc),
      .held_o   (flt_q),
      .hi_o     (out_hi),
      .lo_o     (out_lo)
   );

endmodule

module apwm_channel_chk #(
   parameter int CNT_W    = 16,
   parameter int SEL_W    = 4,
   parameter int STOP_MIN = 13
) (
   input logic             clk,
   input logic             rst_n,
   input logic [SEL_W-1:0] tap_sel,
   input logic             fault_in,
   input logic             fault_clr,
   input logic             flt_lvl_hi,
   input logic             flt_lvl_lo,
   input logic             out_hi,
   input logic             out_lo,
   input logic             flt_q,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] per_q,
   input logic [CNT_W-1:0] dty_q,
   input logic             bnd
);
   // R10
   flt_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_in |-> (out_hi == flt_lvl_hi && out_lo == flt_lvl_lo));

   // R11
   flt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_in |=> flt_q);

   // R11
   flt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_q && !(fault_clr && !fault_in)) |=> flt_q);

   // R8
   comp_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!fault_in && !flt_q) |-> (out_lo != out_hi));

   // R9
   shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bnd |=> ($stable(per_q) && $stable(dty_q)));

   // R4
   stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tap_sel >= SEL_W'(STOP_MIN)) |=> $stable(cnt));

   // R6
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= per_q);

endmodule

bind apwm_channel apwm_channel_chk #(
   .CNT_W    (CNT_W),
   .SEL_W    (SEL_W),
   .STOP_MIN (NUM_TAPS + NUM_DIV)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tap_sel    (tap_sel),
   .fault_in   (fault_in),
   .fault_clr  (fault_clr),
   .flt_lvl_hi (flt_lvl_hi),
   .flt_lvl_lo (flt_lvl_lo),
   .out_hi     (out_hi),
   .out_lo     (out_lo),
   .flt_q      (flt_q),
   .cnt        (cnt),
   .per_q      (per_q),
   .dty_q      (dty_q),
   .bnd        (bnd)
);

// File: tb/apwm_channel_tb.sv
`timescale 1ns/1ps
module apwm_channel_tb;

   localparam int LIMIT = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  tap_sel = '0, diva_tap = '0, divb_tap = '0;
   logic [7:0]  diva_val = '0, divb_val = '0;
   logic        center_en = 1'b0;
   logic [15:0] period_in = '0, duty_in = '0;
   logic        fault_in = 1'b0, fault_clr = 1'b0;
   logic        flt_lvl_hi = 1'b0, flt_lvl_lo = 1'b0;
   logic        out_hi, out_lo;

   int checks = 0;
   int errors = 0;
   int lo_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   apwm_channel u_dut (
      .clk(clk), .rst_n(rst_n), .tap_sel(tap_sel),
      .diva_tap(diva_tap), .diva_val(diva_val),
      .divb_tap(divb_tap), .divb_val(divb_val),
      .center_en(center_en), .period_in(period_in), .duty_in(duty_in),
      .fault_in(fault_in), .fault_clr(fault_clr),
      .flt_lvl_hi(flt_lvl_hi), .flt_lvl_lo(flt_lvl_lo),
      .out_hi(out_hi), .out_lo(out_lo)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int tick_len(input int t, input int ta, input int na,
                                   input int tb, input int nb);
      int tt;
      int n;
      if (t < 11) return 1 << t;
      if (t == 11) begin tt = ta; n = na; end
      else if (t == 12) begin tt = tb; n = nb; end
      else return 0;
      if (tt > 10) tt = 10;
      if (n == 0) n = 1;
      return (1 << tt) * n;
   endfunction

   task automatic apply(input int t, input int ta, input int na, input int tb,
                        input int nb, input bit c, input int p, input int d);
      tap_sel   = 4'(t);
      diva_tap  = 4'(ta);
      diva_val  = 8'(na);
      divb_tap  = 4'(tb);
      divb_val  = 8'(nb);
      center_en = c;
      period_in = 16'(p);
      duty_in   = 16'(d);
   endtask

   // period between the 2nd and 3rd rising edges, and the high time inside it
   task automatic measure(output int per_c, output int hi_c);
      int  rises = 0;
      int  cyc   = 0;
      int  start = 0;
      bit  prev;
      per_c = -1;
      hi_c  = 0;
      @(negedge clk);
      prev = out_hi;
      while (rises < 3 && cyc < LIMIT) begin
         @(negedge clk);
         cyc++;
         if (out_lo == out_hi) lo_bad++;
         if (out_hi && !prev) begin
            rises++;
            if (rises == 2) start = cyc;
            if (rises == 3) per_c = cyc - start;
         end
         if (rises == 2 && out_hi) hi_c++;
         prev = out_hi;
      end
   endtask

   task automatic run_case(input string req, input int t, input int ta, input int na,
                           input int tb, input int nb, input bit c, input int p,
                           input int d);
      int pm, hm, tl, mul;
      apply(t, ta, na, tb, nb, c, p, d);
      measure(pm, hm);
      tl  = tick_len(t, ta, na, tb, nb);
      mul = c ? 2 : 1;
      chk({req, " period"}, pm, tl * p * mul);
      chk({req, " high time"}, hm, tl * (p - d) * mul);
   endtask

   task automatic count_high(input int n, output int highs);
      highs = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (out_hi) highs++;
      end
   endtask

   initial begin : watchdog
      #(8 * 190000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual 0 expected 1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      int pm, hm, hs, chg, run;
      bit v;
      void'($urandom(32'd7741));
      apply(0, 0, 1, 0, 1, 1'b0, 10, 3);
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 out_hi in reset", int'(out_hi), 0);
      chk("R1 out_lo in reset", int'(out_lo), 1);
      rst_n = 1'b1;

      // R5, R2: edge aligned, fastest tap
      run_case("R5", 0, 0, 1, 0, 1, 1'b0, 10, 3);
      // R6: centre aligned
      run_case("R6", 0, 0, 1, 0, 1, 1'b1, 10, 3);
      run_case("R6 D=1", 1, 0, 1, 0, 1, 1'b1, 6, 1);
      // R2: slowest tap
      run_case("R2 tap10", 10, 0, 1, 0, 1, 1'b0, 2, 1);
      run_case("R2 tap3", 3, 0, 1, 0, 1, 1'b1, 4, 3);
      // R3: dividers, clamping of tap and zero value
      run_case("R3 divA", 11, 2, 3, 0, 1, 1'b0, 5, 2);
      run_case("R3 divB clamp", 12, 0, 1, 14, 0, 1'b0, 2, 1);
      chk("R8 pairing", lo_bad, 0);

      // R7: constant levels
      apply(0, 0, 1, 0, 1, 1'b0, 8, 0);
      repeat (40) @(negedge clk);
      count_high(64, hs);
      chk("R7 duty 0 edge", hs, 64);
      center_en = 1'b1;
      repeat (40) @(negedge clk);
      count_high(64, hs);
      chk("R7 duty 0 centre", hs, 64);
      duty_in = 16'd8;
      repeat (40) @(negedge clk);
      count_high(64, hs);
      chk("R7 duty=P centre", hs, 0);
      center_en = 1'b0;
      duty_in = 16'd200;
      repeat (40) @(negedge clk);
      count_high(64, hs);
      chk("R7 duty>P edge", hs, 0);

      // R4: stopped tick source
      for (int code = 13; code < 16; code += 2) begin
         apply(0, 0, 1, 0, 1, 1'b0, 50, 25);
         repeat (60 + code) @(negedge clk);
         tap_sel = 4'(code);
         @(negedge clk);
         v = out_hi;
         chg = 0;
         for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (out_hi != v) chg++;
         end
         chk("R4 outputs hold", chg, 0);
      end

      // R9: duty change mid-cycle waits for the wrap
      apply(0, 0, 1, 0, 1, 1'b0, 40, 10);
      measure(pm, hm);
      chk("R9 setup period", pm, 40);
      duty_in = 16'd30;
      run = 1;
      while (out_hi && run < 200) begin @(negedge clk); if (out_hi) run++; end
      chk("R9 high phase keeps old duty", run, 30);
      run = 0;
      while (!out_hi && run < 200) begin @(negedge clk); run++; end
      chk("R9 low phase uses new duty", run, 30);

      // R10, R11: fault override
      apply(0, 0, 1, 0, 1, 1'b0, 10, 3);
      repeat (30) @(negedge clk);
      #2;
      flt_lvl_hi = 1'b1;
      flt_lvl_lo = 1'b1;
      fault_in   = 1'b1;
      #1;
      chk("R10 immediate force", int'({out_hi, out_lo}), 3);
      @(negedge clk);
      fault_clr = 1'b1;
      repeat (2) @(negedge clk);
      fault_clr = 1'b0;
      fault_in  = 1'b0;
      repeat (4) @(negedge clk);
      chk("R11 held after release", int'({out_hi, out_lo}), 3);
      flt_lvl_hi = 1'b0;
      flt_lvl_lo = 1'b1;
      #1;
      chk("R10 level follows while held", int'({out_hi, out_lo}), 1);
      repeat (20) @(negedge clk);
      chk("R11 still held", int'({out_hi, out_lo}), 1);
      fault_clr = 1'b1;
      @(negedge clk);
      fault_clr = 1'b0;
      lo_bad = 0;
      run_case("R11 after clear", 0, 0, 1, 0, 1, 1'b0, 10, 3);
      chk("R8 pairing after clear", lo_bad, 0);

      // R2, R3, R5, R6: random settings
      for (int it = 0; it < 16; it++) begin
         int t, ta, na, tb, nb, p, d;
         bit c;
         t  = $urandom_range(0, 6);
         if (t == 5) t = 11;
         if (t == 6) t = 12;
         ta = $urandom_range(0, 2);
         na = $urandom_range(0, 4);
         tb = $urandom_range(0, 2);
         nb = $urandom_range(0, 4);
         p  = $urandom_range(2, 16);
         d  = $urandom_range(1, p - 1);
         c  = 1'($urandom_range(0, 1));
         run_case(c ? "R6 random" : "R5 random", t, ta, na, tb, nb, c, p, d);
      end
      chk("R8 pairing random", lo_bad, 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule